// File: doc/BRIEF.md
# Monitor Slot Handshake Receiver

This block takes in monitor-slot bytes from a time-division serial bus. The bus is already split into slots, and the block sees them once per frame. A frame strobe marks each frame. On each strobe the block samples the active-low transmit-strobe bit of the chosen slot together with that slot's data byte. It answers with an active-low acknowledge bit, `mr_n`, which the serialiser puts back on the bus. A received byte waits in a receive register until the CPU reads it, and every accepted byte raises a one-cycle interrupt pulse.

The acknowledge bit controls the pace of the remote transmitter. It goes active when the first byte of a message arrives. It drops when the CPU takes a byte, and it comes back one full frame later, so the remote side can never get ahead of the CPU. When the transmit strobe stays quiet for two frames, the message has ended. If a byte arrives while the previous one is still unread, the new byte is dropped, an overrun flag is set, and the acknowledge bit is held inactive until the message ends. The remote side reads this as an abort.

Top module: `mon_rx`

## Requirements
- R1: After reset, `mr_n`=1, `rx_avail`=0, `rx_irq`=0, `eom_irq`=0, `abort_act`=0, `overrun`=0 and `rx_data`=0.
- R2: `slot_sel`=0 selects `mx_n_in[0]` and `slot_data[7:0]`, and `slot_sel`=1 selects `mx_n_in[1]` and `slot_data[15:8]`. Activity on the unselected slot has no effect on any output.
- R3: When no message is in progress and a strobe samples the selected transmit bit at 0 after it was 1 at the previous strobe, the block loads that strobe's byte, sets `rx_avail`, pulses `rx_irq` for one cycle and drives `mr_n`=0. All of these are visible in the cycle after the strobe.
- R4: During a message, a byte is captured only at a strobe that samples the transmit bit at 1 after a 0. That strobe's byte is loaded and `rx_irq` pulses. Strobes that repeat the active level capture nothing.
- R5: A `cpu_rd` pulse while `rx_avail`=1 clears `rx_avail` and makes `mr_n`=1 from the next cycle. `mr_n` returns to 0 in the cycle after the second strobe that follows the read. A `cpu_rd` pulse while `rx_avail`=0 leaves `mr_n` unchanged.
- R6: Once active, `mr_n` stays 0 until a read, an end of message or an overrun. Frames without a capture do not change it.
- R7: During a message, if the transmit bit is sampled at 1 on two consecutive strobes, `eom_irq` pulses and `mr_n`=1. The next 1-to-0 transition starts a new message as in R3.
- R8: A capture while `rx_avail`=1 is dropped: `rx_data` is unchanged, and `overrun` and `abort_act` go to 1. `mr_n` stays 1 and nothing is captured until the end of message clears `abort_act`. A `cpu_rd` clears `overrun`.
- R9: `rx_data` changes only in a cycle in which `rx_irq` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_stb | input | 1 | One-cycle pulse, once per frame |
| slot_sel | input | 1 | Selects monitor slot 0 or 1 |
| mx_n_in | input | 2 | Incoming transmit-strobe bit per slot, active low |
| slot_data | input | 16 | Slot bytes, slot i at bits [8i+7:8i] |
| cpu_rd | input | 1 | One-cycle read strobe of the receive register |
| mr_n | output | 1 | Outgoing acknowledge bit, active low |
| rx_data | output | 8 | Receive register |
| rx_avail | output | 1 | An unread byte is held |
| rx_irq | output | 1 | One-cycle pulse per accepted byte |
| eom_irq | output | 1 | One-cycle pulse at end of message |
| abort_act | output | 1 | Abort response in progress |
| overrun | output | 1 | A byte was lost, cleared by read |

## Verification
The properties assume that `frame_stb` and `cpu_rd` are single-cycle pulses, that a read never lands in a strobe cycle, and that `slot_sel` changes only while no message is in progress. The stimulus keeps to these assumptions. Strobes arrive every eight cycles, reads are placed in the middle of a frame, and the slot is switched only after an end of message. Under these conditions the acknowledge bit can rise only because of a read, an end of message or an abort. The receive register can change only together with the interrupt pulse.

// File: rtl/mon_rx_pkg.sv
package mon_rx_pkg;
  localparam int NSLOT = 2;

  typedef enum logic [1:0] {
    ACK_IDLE  = 2'd0,
    ACK_ON    = 2'd1,
    ACK_GAP   = 2'd2,
    ACK_ABORT = 2'd3
  } ack_state_e;

  // active-high view of the selected slot's active-low strobe bit
  function automatic logic mx_active(input logic [NSLOT-1:0] mx_n, input logic sel);
    return ~mx_n[sel];
  endfunction

  function automatic logic in_message(input ack_state_e s);
    return s != ACK_IDLE;
  endfunction

  // states in which a falling strobe carries a new byte
  function automatic logic takes_fall(input ack_state_e s);
    return (s == ACK_ON) || (s == ACK_GAP);
  endfunction
endpackage

// File: rtl/mon_rx_sampler.sv
module mon_rx_sampler
  import mon_rx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int EOM_FRAMES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    frame_stb,
  input  logic                    slot_sel,
  input  logic [NSLOT-1:0]        mx_n_in,
  input  logic [NSLOT*DATA_W-1:0] slot_data,
  output logic                    mx_rise,
  output logic                    mx_fall,
  output logic                    quiet_evt,
  output logic [DATA_W-1:0]       cur_byte
);
  localparam int CNT_W = $clog2(EOM_FRAMES + 1);
  localparam logic [CNT_W-1:0] RUN_MAX  = CNT_W'(EOM_FRAMES);
  localparam logic [CNT_W-1:0] RUN_LAST = CNT_W'(EOM_FRAMES - 1);

  logic [DATA_W-1:0] slot_byte [NSLOT];
  logic              mx_now;
  logic              mx_prev;
  logic [CNT_W-1:0]  quiet_run;

  for (genvar g = 0; g < NSLOT; g++) begin : g_unpack
    assign slot_byte[g] = slot_data[g*DATA_W +: DATA_W];
  end

  assign mx_now    = mx_active(mx_n_in, slot_sel);
  assign cur_byte  = slot_byte[slot_sel];
  assign mx_rise   = frame_stb & mx_now & ~mx_prev;
  assign mx_fall   = frame_stb & ~mx_now & mx_prev;
  assign quiet_evt = frame_stb & ~mx_now & (quiet_run == RUN_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mx_prev   <= 1'b0;
      quiet_run <= RUN_MAX;
    end else if (frame_stb) begin
      mx_prev <= mx_now;
      if (mx_now)
        quiet_run <= '0;
      else if (quiet_run != RUN_MAX)
        quiet_run <= quiet_run + 1'b1;
    end
  end
endmodule

// File: rtl/mon_rx_buffer.sv
module mon_rx_buffer #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_req,
  input  logic [DATA_W-1:0] byte_in,
  input  logic              cpu_rd,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_avail,
  output logic              rx_irq,
  output logic              overrun,
  output logic              ovr_evt
);
  logic take;

  // a read in the same cycle frees the register first
  assign ovr_evt = cap_req & rx_avail & ~cpu_rd;
  assign take    = cap_req & ~ovr_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data  <= '0;
      rx_avail <= 1'b0;
      rx_irq   <= 1'b0;
      overrun  <= 1'b0;
    end else begin
      rx_irq <= take;
      if (take) begin
        rx_data  <= byte_in;
        rx_avail <= 1'b1;
      end else if (cpu_rd) begin
        rx_avail <= 1'b0;
      end
      if (ovr_evt)
        overrun <= 1'b1;
      else if (cpu_rd)
        overrun <= 1'b0;
    end
  end
endmodule

// File: rtl/mon_rx_ack.sv
module mon_rx_ack
  import mon_rx_pkg::*;
#(
  parameter int GAP_FRAMES = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_stb,
  input  logic mx_rise,
  input  logic mx_fall,
  input  logic quiet_evt,
  input  logic ovr_evt,
  input  logic rd_hit,
  output logic cap_req,
  output logic mr_n,
  output logic abort_act,
  output logic eom_irq
);
  localparam int GAP_W = $clog2(GAP_FRAMES + 1);
  localparam logic [GAP_W-1:0] GAP_END = GAP_W'(GAP_FRAMES);

  ack_state_e       state, state_nx;
  logic [GAP_W-1:0] gap_cnt, gap_nx;
  logic             eom_nx;

  assign cap_req = ((state == ACK_IDLE) & mx_rise) | (takes_fall(state) & mx_fall);

  always_comb begin
    state_nx = state;
    gap_nx   = gap_cnt;
    eom_nx   = 1'b0;
    if (quiet_evt && in_message(state)) begin
      state_nx = ACK_IDLE;
      eom_nx   = 1'b1;
    end else if (ovr_evt) begin
      state_nx = ACK_ABORT;
    end else begin
      case (state)
        ACK_IDLE: if (cap_req) state_nx = ACK_ON;
        ACK_ON: begin
          if (rd_hit) begin
            state_nx = ACK_GAP;
            gap_nx   = '0;
          end
        end
        ACK_GAP: begin
          if (rd_hit) begin
            gap_nx = '0;
          end else if (frame_stb) begin
            if (gap_cnt == GAP_END) state_nx = ACK_ON;
            else                    gap_nx   = gap_cnt + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ACK_IDLE;
      gap_cnt <= '0;
      eom_irq <= 1'b0;
    end else begin
      state   <= state_nx;
      gap_cnt <= gap_nx;
      eom_irq <= eom_nx;
    end
  end

  assign mr_n      = (state != ACK_ON);
  assign abort_act = (state == ACK_ABORT);
endmodule

// File: rtl/mon_rx.sv
module mon_rx
  import mon_rx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int EOM_FRAMES = 2,
  parameter int GAP_FRAMES = 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    frame_stb,
  input  logic                    slot_sel,
  input  logic [NSLOT-1:0]        mx_n_in,
  input  logic [NSLOT*DATA_W-1:0] slot_data,
  input  logic                    cpu_rd,
  output logic                    mr_n,
  output logic [DATA_W-1:0]       rx_data,
  output logic                    rx_avail,
  output logic                    rx_irq,
  output logic                    eom_irq,
  output logic                    abort_act,
  output logic                    overrun
);
  // named internal events, visible to the bound checker
  logic              mx_rise;
  logic              mx_fall;
  logic              quiet_evt;
  logic [DATA_W-1:0] cur_byte;
  logic              cap_req;
  logic              ovr_evt;
  logic              rd_hit;

  assign rd_hit = cpu_rd & rx_avail;

  mon_rx_sampler #(.DATA_W(DATA_W), .EOM_FRAMES(EOM_FRAMES)) u_sampler (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_stb (frame_stb),
    .slot_sel  (slot_sel),
    .mx_n_in   (mx_n_in),
    .slot_data (slot_data),
    .mx_rise   (mx_rise),
    .mx_fall   (mx_fall),
    .quiet_evt (quiet_evt),
    .cur_byte  (cur_byte)
  );

  mon_rx_buffer #(.DATA_W(DATA_W)) u_buffer (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_req  (cap_req),
    .byte_in  (cur_byte),
    .cpu_rd   (cpu_rd),
    .rx_data  (rx_data),
    .rx_avail (rx_avail),
    .rx_irq   (rx_irq),
    .overrun  (overrun),
    .ovr_evt  (ovr_evt)
  );

  mon_rx_ack #(.GAP_FRAMES(GAP_FRAMES)) u_ack (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_stb (frame_stb),
    .mx_rise   (mx_rise),
    .mx_fall   (mx_fall),
    .quiet_evt (quiet_evt),
    .ovr_evt   (ovr_evt),
    .rd_hit    (rd_hit),
    .cap_req   (cap_req),
    .mr_n      (mr_n),
    .abort_act (abort_act),
    .eom_irq   (eom_irq)
  );
endmodule

// File: rtl/mon_rx_sva.sv
module mon_rx_sva #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_stb,
  input logic              cpu_rd,
  input logic              cap_req,
  input logic              mr_n,
  input logic [DATA_W-1:0] rx_data,
  input logic              rx_avail,
  input logic              rx_irq,
  input logic              eom_irq,
  input logic              abort_act
);
  a_r3_irq_has_data: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> rx_avail);

  a_r4_capture_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    cap_req |-> frame_stb);

  a_r5_read_drops_mr: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && rx_avail && !mr_n) |=> mr_n);

  a_r6_mr_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mr_n) |-> ($past(cpu_rd) || eom_irq || abort_act));

  a_r7_eom_releases: assert property (@(posedge clk) disable iff (!rst_n)
    eom_irq |-> (mr_n && !abort_act));

  a_r8_abort_mr_off: assert property (@(posedge clk) disable iff (!rst_n)
    abort_act |-> mr_n);

  a_r8_abort_no_capture: assert property (@(posedge clk) disable iff (!rst_n)
    abort_act |-> !cap_req);

  a_r9_data_with_irq: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_data) |-> rx_irq);
endmodule

bind mon_rx mon_rx_sva #(.DATA_W(DATA_W)) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .frame_stb (frame_stb),
  .cpu_rd    (cpu_rd),
  .cap_req   (cap_req),
  .mr_n      (mr_n),
  .rx_data   (rx_data),
  .rx_avail  (rx_avail),
  .rx_irq    (rx_irq),
  .eom_irq   (eom_irq),
  .abort_act (abort_act)
);

// File: tb/mon_rx_tb.sv
module mon_rx_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_stb = 1'b0;
  logic        slot_sel = 1'b0;
  logic [1:0]  mx_n_in = 2'b11;
  logic [15:0] slot_data = '0;
  logic        cpu_rd = 1'b0;
  logic        mr_n;
  logic [7:0]  rx_data;
  logic        rx_avail, rx_irq, eom_irq, abort_act, overrun;

  int checks = 0;
  int fails = 0;
  int irq_seen = 0;
  int eom_seen = 0;

  always #2 clk = ~clk;

  mon_rx u_dut (
    .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .slot_sel(slot_sel),
    .mx_n_in(mx_n_in), .slot_data(slot_data), .cpu_rd(cpu_rd),
    .mr_n(mr_n), .rx_data(rx_data), .rx_avail(rx_avail), .rx_irq(rx_irq),
    .eom_irq(eom_irq), .abort_act(abort_act), .overrun(overrun)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural reference: phase 0 idle, 1 acknowledging, 2 waiting out gap, 3 aborting
  int       ph = 0, gap_seen = 0, quiet = 2;
  bit       prev_act = 0, e_avail = 0, e_irq = 0, e_eom = 0, e_ovr = 0;
  bit [7:0] e_data = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      ph = 0; gap_seen = 0; quiet = 2; prev_act = 0;
      e_avail = 0; e_irq = 0; e_eom = 0; e_ovr = 0; e_data = 0;
    end else begin
      bit act, got, lost, ended, hit;
      bit [7:0] b;
      act = slot_sel ? !mx_n_in[1] : !mx_n_in[0];
      b = slot_sel ? slot_data[15:8] : slot_data[7:0];
      got = 0; ended = 0;
      hit = cpu_rd && e_avail;
      if (frame_stb) begin
        if (ph == 0 && act && !prev_act) got = 1;
        if ((ph == 1 || ph == 2) && !act && prev_act) got = 1;
        quiet = act ? 0 : quiet + 1;
        if (quiet == 2 && ph != 0) ended = 1;
        prev_act = act;
      end
      lost = got && e_avail && !cpu_rd;
      e_irq = got && !lost;
      if (e_irq) begin e_data = b; e_avail = 1; end
      else if (cpu_rd) e_avail = 0;
      if (lost) e_ovr = 1; else if (cpu_rd) e_ovr = 0;
      e_eom = ended;
      if (ended) ph = 0;
      else if (lost) ph = 3;
      else if (ph == 0 && got) ph = 1;
      else if (ph == 1 && hit) begin ph = 2; gap_seen = 0; end
      else if (ph == 2) begin
        if (hit) gap_seen = 0;
        else if (frame_stb) begin
          if (gap_seen == 1) ph = 1; else gap_seen++;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (rx_irq) irq_seen++;
      if (eom_irq) eom_seen++;
      chk("R5/R6 mr_n model", mr_n, (ph == 1) ? 0 : 1);
      chk("R9 rx_data model", rx_data, e_data);
      chk("R3 rx_avail model", rx_avail, e_avail);
      chk("R4 rx_irq model", rx_irq, e_irq);
      chk("R7 eom_irq model", eom_irq, e_eom);
      chk("R8 abort_act model", abort_act, ph == 3);
      chk("R8 overrun model", overrun, e_ovr);
    end
  end

  // one frame = 8 cycles; mx bits are the active-low wire values
  task automatic frame(input bit m0, input bit m1, input bit [7:0] d0, input bit [7:0] d1,
                       input int rd_at);
    @(negedge clk);
    mx_n_in = {m1, m0};
    slot_data = {d1, d0};
    frame_stb = 1'b1;
    @(negedge clk);
    frame_stb = 1'b0;
    for (int c = 1; c < 8; c++) begin
      cpu_rd = (c == rd_at);
      @(negedge clk);
    end
    cpu_rd = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk("R1 mr_n", mr_n, 1);
    chk("R1 rx_avail", rx_avail, 0);
    chk("R1 rx_data", rx_data, 0);
    chk("R1 flags", {rx_irq, eom_irq, abort_act, overrun}, 0);
    rst_n = 1'b1;

    // R2: slot 1 busy while slot 0 selected
    frame(1, 0, 8'h00, 8'h33, -1);
    frame(1, 0, 8'h00, 8'h34, -1);
    chk("R2 other slot ignored avail", rx_avail, 0);
    chk("R2 other slot ignored mr_n", mr_n, 1);

    // R3: first byte
    frame(0, 1, 8'hA5, 8'h00, -1);
    chk("R3 first byte", rx_data, 8'hA5);
    chk("R3 avail", rx_avail, 1);
    chk("R3 mr active", mr_n, 0);
    chk("R3 one irq", irq_seen, 1);

    // R4/R6: repeated active frames, no read
    frame(0, 1, 8'hA5, 8'h00, -1);
    frame(0, 1, 8'hA5, 8'h00, -1);
    chk("R6 mr held", mr_n, 0);
    chk("R4 no recapture", irq_seen, 1);

    // R5: read drops MR; capture during gap; back after second strobe
    frame(0, 1, 8'hA5, 8'h00, 3);
    chk("R5 mr off after read", mr_n, 1);
    chk("R5 avail cleared", rx_avail, 0);
    frame(1, 1, 8'h5A, 8'h00, -1);
    chk("R4 falling capture", rx_data, 8'h5A);
    chk("R5 mr still off", mr_n, 1);
    frame(0, 1, 8'h5A, 8'h00, -1);
    chk("R5 mr back", mr_n, 0);
    frame(0, 1, 8'h5A, 8'h00, 2);
    frame(0, 1, 8'h5A, 8'h00, -1);
    frame(0, 1, 8'h5A, 8'h00, -1);
    chk("R5 mr back again", mr_n, 0);
    frame(0, 1, 8'h5A, 8'h00, 4);
    chk("R5 empty read ignored", mr_n, 0);

    // R7: last byte then quiet
    frame(1, 1, 8'hC3, 8'h00, -1);
    chk("R4 third byte", rx_data, 8'hC3);
    frame(1, 1, 8'hC3, 8'h00, 3);
    chk("R7 eom seen", eom_seen, 1);
    chk("R7 mr off", mr_n, 1);
    frame(1, 1, 8'h00, 8'h00, -1);

    // R8: overrun
    frame(0, 1, 8'h11, 8'h00, -1);
    chk("R7 new message", rx_data, 8'h11);
    frame(1, 1, 8'h22, 8'h00, -1);
    chk("R8 byte dropped", rx_data, 8'h11);
    chk("R8 overrun", overrun, 1);
    chk("R8 abort", abort_act, 1);
    chk("R8 mr off", mr_n, 1);
    frame(0, 1, 8'h22, 8'h00, -1);
    frame(1, 1, 8'h33, 8'h00, -1);
    chk("R8 no capture in abort", rx_data, 8'h11);
    frame(1, 1, 8'h33, 8'h00, -1);
    chk("R8 abort ends", abort_act, 0);
    chk("R7 second eom", eom_seen, 2);
    frame(1, 1, 8'h00, 8'h00, 2);
    chk("R8 overrun cleared", overrun, 0);

    // R2: slot 1 selected, slot 0 noisy
    slot_sel = 1'b1;
    frame(0, 1, 8'h99, 8'h00, -1);
    chk("R2 slot0 ignored", rx_avail, 0);
    frame(1, 0, 8'hEE, 8'h77, 3);
    chk("R2 slot1 byte", rx_data, 8'h77);
    frame(0, 1, 8'h98, 8'h78, -1);
    chk("R2 slot1 second byte", rx_data, 8'h78);
    frame(0, 1, 8'h00, 8'h00, 3);
    chk("R7 slot1 eom", eom_seen, 3);
    chk("R4 total irq", irq_seen, 6);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule